// File: doc/BRIEF.md
# Eight-Level Priority Interrupt Controller

This block collects eight interrupt request lines and presents one interrupt line to a processor. Each request is latched in a pending register, either on a rising edge or by following the input level. A mask register gates the pending requests before a priority resolver picks one. While any line is in service, a new request only raises the interrupt output if it outranks every in-service line, so service routines nest by priority.

When the processor acknowledges, the winning line moves from the pending register into the in-service register and an 8-bit vector is latched. The vector is a programmable base plus the line index times a spacing of four or eight. Software ends service with a non-specific end-of-interrupt, which retires the highest-ranked in-service line, or with a specific one that names the line. The priority order is fixed with line 0 on top, rotates automatically so that a retired line drops to the bottom, or is rotated by software to a named bottom line.

The register port is a chip select, a write strobe, one address bit and an 8-bit data bus. Address 0 takes command words, and address 1 takes data for a register chosen by an earlier command. Reads are combinational.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the interrupt output is low, the vector is 0, the pending, in-service and mask registers are 0, every line is edge-triggered, the base is 0, the spacing is 4, rotation is off, the bottom-priority line is 7, address 0 reads pending and address 1 writes go to the mask.
- R2: In edge mode a rising input sets its pending bit, which stays set until that line is acknowledged. An input that stays high does not set the bit again.
- R3: In level mode a pending bit equals its input as sampled at the previous clock edge.
- R4: A masked line still shows in the pending register but never raises the interrupt output or wins priority.
- R5: The interrupt output is high exactly when some unmasked line is pending and the best-ranked such line outranks every set in-service bit. With no rotation, line 0 ranks highest and line 7 lowest.
- R6: An acknowledge while the interrupt output is high clears the winner's pending bit (edge mode), sets its in-service bit, and from the next cycle vec_out holds (base + index x spacing) mod 256.
- R7: Command 0x20 (non-specific end of interrupt) clears the best-ranked in-service bit.
- R8: Command 0x60|n (specific end of interrupt) clears in-service bit n.
- R9: With automatic rotation on, a non-specific end of interrupt also makes the retired line the lowest-ranked one.
- R10: Command 0x80|n makes line n lowest-ranked, and 0xA0|n does that and also clears in-service bit n.
- R11: Command 0xC0|b sets auto-rotation (b bit 0), spacing 8 (bit 1) and in-service readback (bit 2). Command 0xE0|(s<<3) routes later address-1 writes to the mask (s=0), the level-mode bits (s=1) or the vector base (s=2). A read at address 1 returns the mask, and a read at address 0 returns pending or in-service. rdata is 0 when cs is low.
- R12: An acknowledge while the interrupt output is low changes neither the in-service register nor the vector.
- R13: A rising edge on a line in the same cycle that line is acknowledged leaves its pending bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Request lines |
| ack | input | 1 | Acknowledge pulse from processor |
| cs | input | 1 | Register port select |
| wr | input | 1 | Write strobe, one cycle per write |
| a0 | input | 1 | Register address bit |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| int_out | output | 1 | Interrupt request to processor |
| vec_out | output | 8 | Vector latched at acknowledge |

## Verification
Two pairs of functions can fall in the same cycle. The first is an acknowledge that clears a line's pending bit while a fresh rising edge on that line sets it again. The bench provokes this by dropping the line and raising it again in the acknowledge cycle, and expects the bit to stay pending with the line also in service. The second is an acknowledge in a cycle where the interrupt output is low. This is produced in a state where a pending line is blocked by an equal in-service line, and the bench expects the in-service register and the vector to stay unchanged. A behavioural model compares the interrupt output, the vector and the read data every clock.

// File: rtl/prio_irq_ctrl.sv
`timescale 1ns/1ps
module prio_irq_ctrl #(
  parameter int LINES = 8,
  parameter int VW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] irq_in,
  input  logic             ack,
  input  logic             cs,
  input  logic             wr,
  input  logic             a0,
  input  logic [7:0]       wdata,
  output logic [VW-1:0]    rdata,
  output logic             int_out,
  output logic [VW-1:0]    vec_out
);
  localparam int IW = $clog2(LINES);

  logic [LINES-1:0] irr, isr, imr, trig, prev;
  logic [VW-1:0]    base, vec_q;
  logic [IW-1:0]    low;
  logic             auto_rot, sp8, rsel;
  logic [1:0]       wsel;

  wire             cmd_wr = cs & wr & ~a0;
  wire             dat_wr = cs & wr & a0;
  wire [2:0]       op     = wdata[7:5];
  wire [IW-1:0]    arg    = wdata[IW-1:0];
  wire             eoi_ns = cmd_wr & (op == 3'b001);
  wire             eoi_sp = cmd_wr & ((op == 3'b011) | (op == 3'b101));
  wire             rot_set = cmd_wr & ((op == 3'b100) | (op == 3'b101));
  wire [LINES-1:0] pend   = irr & ~imr;
  wire [LINES-1:0] rise   = irq_in & ~prev;

  logic [IW-1:0] win, isr_top, idx;
  logic [IW:0]   win_rank, isr_rank;
  logic          win_ok, isr_hit;

  always_comb begin
    win = '0; win_ok = 1'b0; win_rank = '0;
    isr_top = '0; isr_hit = 1'b0; isr_rank = '0;
    idx = '0;
    for (int k = 0; k < LINES; k++) begin
      idx = low + IW'(k + 1);
      if (pend[idx] && !win_ok) begin
        win = idx; win_ok = 1'b1; win_rank = (IW+1)'(k);
      end
      if (isr[idx] && !isr_hit) begin
        isr_top = idx; isr_hit = 1'b1; isr_rank = (IW+1)'(k);
      end
    end
  end

  assign int_out = win_ok & (~isr_hit | (win_rank < isr_rank));
  wire take = ack & int_out;

  wire [LINES-1:0] isr_set = take ? (LINES'(1) << win) : '0;
  wire [LINES-1:0] isr_clr = (eoi_ns & isr_hit) ? (LINES'(1) << isr_top) :
                             eoi_sp ? (LINES'(1) << arg) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr <= '0; isr <= '0; imr <= '0; trig <= '0; prev <= '0;
      base <= '0; vec_q <= '0; low <= IW'(LINES - 1);
      auto_rot <= 1'b0; sp8 <= 1'b0; rsel <= 1'b0; wsel <= 2'd0;
    end else begin
      prev <= irq_in;
      irr  <= (trig & irq_in) | (~trig & ((irr & ~isr_set) | rise));
      isr  <= (isr & ~isr_clr) | isr_set;
      if (take)
        vec_q <= base + (VW'(win) << (sp8 ? 3 : 2));
      if (rot_set)
        low <= arg;
      else if (eoi_ns && auto_rot && isr_hit)
        low <= isr_top;
      if (cmd_wr && op == 3'b110) begin
        auto_rot <= wdata[0];
        sp8      <= wdata[1];
        rsel     <= wdata[2];
      end
      if (cmd_wr && op == 3'b111)
        wsel <= wdata[4:3];
      if (dat_wr) begin
        case (wsel)
          2'd0: imr  <= wdata[LINES-1:0];
          2'd1: trig <= wdata[LINES-1:0];
          2'd2: base <= wdata[VW-1:0];
          default: ;
        endcase
      end
    end
  end

  assign vec_out = vec_q;
  assign rdata   = !cs ? '0 : a0 ? VW'(imr) : (rsel ? VW'(isr) : VW'(irr));

  a_r4_masked_no_int: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> ((irr & ~imr) != '0));
  a_r6_ack_adds_isr: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !cmd_wr) |=> ($countones(isr) == $countones($past(isr)) + 1));
  a_r7_eoi_drops_isr: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_ns && isr_hit && !take) |=> ($countones(isr) == $countones($past(isr)) - 1));
  a_r10_rotate_named: assert property (@(posedge clk) disable iff (!rst_n)
    rot_set |=> (low == $past(arg)));
  a_r12_idle_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !int_out && !cmd_wr) |=> ($stable(isr) && $stable(vec_out)));
endmodule

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] irq_in = '0, wdata = '0;
  logic ack = 1'b0, cs = 1'b0, wr = 1'b0, a0 = 1'b0;
  logic [7:0] rdata, vec_out;
  logic int_out;

  prio_irq_ctrl u_dut (.clk(clk), .rst_n(rst_n), .irq_in(irq_in), .ack(ack),
    .cs(cs), .wr(wr), .a0(a0), .wdata(wdata), .rdata(rdata),
    .int_out(int_out), .vec_out(vec_out));

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0] m_irr = 0, m_isr = 0, m_imr = 0, m_trig = 0, m_prev = 0, m_base = 0, m_vec = 0;
  int m_low = 7;
  bit m_auto = 0, m_sp8 = 0, m_rsel = 0;
  int m_wsel = 0;

  function automatic int rank(int i);
    return (i - m_low - 1 + 16) % 8;
  endfunction
  function automatic int best(logic [7:0] v);
    int b = -1;
    for (int i = 0; i < 8; i++)
      if (v[i] && (b < 0 || rank(i) < rank(b))) b = i;
    return b;
  endfunction
  function automatic bit m_int();
    int w = best(m_irr & ~m_imr);
    int t = best(m_isr);
    return (w >= 0) && (t < 0 || rank(w) < rank(t));
  endfunction
  function automatic logic [7:0] m_read();
    if (!cs) return 8'h00;
    if (a0) return m_imr;
    return m_rsel ? m_isr : m_irr;
  endfunction

  task automatic model_step();
    int w = best(m_irr & ~m_imr);
    int t = best(m_isr);
    bit take = ack && m_int();
    bit cw = cs && wr && !a0;
    bit dw = cs && wr && a0;
    int op = wdata[7:5];
    int n = wdata[2:0];
    logic [7:0] clr = 0, nirr;
    if (cw && op == 1 && t >= 0) clr[t] = 1;
    if (cw && (op == 3 || op == 5)) clr[n] = 1;
    for (int i = 0; i < 8; i++)
      nirr[i] = m_trig[i] ? irq_in[i] :
                ((m_irr[i] && !(take && i == w)) || (irq_in[i] && !m_prev[i]));
    m_isr = m_isr & ~clr;
    if (take) begin
      m_isr[w] = 1;
      m_vec = 8'((m_base + w * (m_sp8 ? 8 : 4)) % 256);
    end
    m_irr = nirr;
    m_prev = irq_in;
    if (cw && (op == 4 || op == 5)) m_low = n;
    else if (cw && op == 1 && m_auto && t >= 0) m_low = t;
    if (cw && op == 6) begin m_auto = wdata[0]; m_sp8 = wdata[1]; m_rsel = wdata[2]; end
    if (cw && op == 7) m_wsel = wdata[4:3];
    if (dw) begin
      if (m_wsel == 0) m_imr = wdata;
      else if (m_wsel == 1) m_trig = wdata;
      else if (m_wsel == 2) m_base = wdata;
    end
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    #2;
    chk("R5 int_out per-cycle", int_out, m_int());
    chk("R6 vec_out per-cycle", vec_out, m_vec);
    chk("R11 rdata per-cycle", rdata, m_read());
  endtask
  task automatic cmd(logic [7:0] b);
    cs = 1; wr = 1; a0 = 0; wdata = b; cyc(); cs = 0; wr = 0;
  endtask
  task automatic wdat(logic [7:0] b);
    cs = 1; wr = 1; a0 = 1; wdata = b; cyc(); cs = 0; wr = 0; a0 = 0;
  endtask
  task automatic do_ack();
    ack = 1; cyc(); ack = 0;
  endtask
  task automatic rdchk(string tag, bit a, int exp);
    cs = 1; wr = 0; a0 = a; #1;
    chk(tag, rdata, exp);
    cs = 0; a0 = 0; #1;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    // R1 reset state
    chk("R1 int_out", int_out, 0);
    chk("R1 vec_out", vec_out, 0);
    rdchk("R1 pending", 0, 0);
    rdchk("R1 mask", 1, 0);

    // R2 edge capture, R6 acknowledge
    irq_in = 8'h08; cyc();
    rdchk("R2 pending set", 0, 8'h08);
    chk("R5 int raised", int_out, 1);
    do_ack();
    chk("R6 vector line3", vec_out, 12);
    rdchk("R6 pending cleared", 0, 0);
    cyc(); cyc();
    rdchk("R2 steady high no reset", 0, 0);
    cmd(8'hC4);
    rdchk("R11 in-service readback", 0, 8'h08);
    cmd(8'hC0);

    // R5 nesting, R7, R8
    irq_in = 8'h28; cyc();
    chk("R5 lower blocked", int_out, 0);
    irq_in = 8'h2A; cyc();
    chk("R5 higher nests", int_out, 1);
    do_ack();
    chk("R6 vector line1", vec_out, 4);
    cmd(8'h20);
    cmd(8'hC4);
    rdchk("R7 non-specific eoi", 0, 8'h08);
    cmd(8'h63);
    rdchk("R8 specific eoi", 0, 8'h00);
    cmd(8'hC0);
    chk("R5 line5 unblocked", int_out, 1);
    do_ack();
    chk("R6 vector line5", vec_out, 20);
    cmd(8'h20);
    irq_in = 0; cyc();

    // R4 masking
    wdat(8'h04);
    irq_in = 8'h04; cyc();
    chk("R4 masked no int", int_out, 0);
    rdchk("R4 masked still pending", 0, 8'h04);
    rdchk("R11 mask readback", 1, 8'h04);
    wdat(8'h00);
    chk("R4 unmasked int", int_out, 1);
    do_ack(); cmd(8'h20);
    irq_in = 0; cyc();

    // R11 base and spacing, R6 wrap
    cmd(8'hF0); wdat(8'hF0); cmd(8'hC2); cmd(8'hE0);
    irq_in = 8'h40; cyc(); do_ack();
    chk("R6 spacing8 wrap", vec_out, 8'h20);
    cmd(8'h20); cmd(8'hC0);
    irq_in = 0; cyc();

    // R3 level mode
    cmd(8'hE8); wdat(8'h01); cmd(8'hE0);
    irq_in = 8'h01; cyc();
    rdchk("R3 level high", 0, 8'h01);
    irq_in = 8'h00; cyc();
    rdchk("R3 level low", 0, 8'h00);
    chk("R3 int dropped", int_out, 0);
    cmd(8'hE8); wdat(8'h00); cmd(8'hE0);

    // R9 automatic rotation
    cmd(8'hC1);
    irq_in = 8'h01; cyc(); do_ack(); cmd(8'h20);
    irq_in = 8'h00; cyc();
    irq_in = 8'h03; cyc(); do_ack();
    chk("R9 line0 rotated low", vec_out, 8'hF4);
    cmd(8'h20);
    do_ack();
    chk("R9 line0 after rotate", vec_out, 8'hF0);
    cmd(8'h20); cmd(8'hC0);
    irq_in = 0; cyc();

    // R10 specific rotation
    cmd(8'h83);
    irq_in = 8'h14; cyc(); do_ack();
    chk("R10 line4 first", vec_out, 8'h00);
    cmd(8'h20);
    do_ack();
    chk("R10 line2 second", vec_out, 8'hF8);
    cmd(8'hA2);
    cmd(8'hC4);
    rdchk("R10 rotate+eoi clears", 0, 8'h00);
    cmd(8'hC0);
    cmd(8'h87);
    irq_in = 0; cyc();

    // R12 idle acknowledge
    do_ack();
    chk("R12 vec held", vec_out, 8'hF8);
    cmd(8'hC4);
    rdchk("R12 isr held", 0, 8'h00);
    cmd(8'hC0);

    // R13 edge during acknowledge
    irq_in = 8'h40; cyc();
    irq_in = 8'h00; cyc();
    irq_in = 8'h40; ack = 1; cyc(); ack = 0;
    rdchk("R13 pending kept", 0, 8'h40);
    chk("R5 equal rank blocked", int_out, 0);
    do_ack();
    cmd(8'hC4);
    rdchk("R12 blocked ack isr", 0, 8'h40);
    cmd(8'hC0);
    cmd(8'h20);
    chk("R13 re-request int", int_out, 1);
    do_ack();
    rdchk("R13 second service", 0, 8'h00);
    cmd(8'h20);
    irq_in = 0; cyc(); cyc();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule